// File: doc/BRIEF.md
# RC Oscillator Enable and Trim Controller

This block is the digital control around an on-chip, multi-range RC oscillator. The analog core is outside it. The block turns the oscillator on and off from a single enable level. It synchronises the core's stable indication into the control clock to form a ready flag. It passes the oscillator clock to its output only while that flag is set. Software can wake the oscillator as a restart clock or keep it as a fallback clock just by raising the enable, and it sees a clean clock only once the core has settled.

The frequency trim sent to the core is the sum of two values, clamped to the unsigned 8-bit range. The first is an 8-bit calibration value that is fixed at reset. The second is a signed 8-bit user trim that software writes. A lock mode can be requested while a 32.768 kHz reference reports ready. In lock mode the block counts oscillator edges over a fixed number of reference periods. It compares that count with a target for the selected range, and after each window it moves the user trim by one step towards the target. This works in every range. Both the oscillator and the reference are sampled into the control clock domain, so the oscillator must run below half the control clock rate.

Top module: `rcosc_ctrl`

## Requirements
- R1: `osc_on` follows `en` one control-clock edge later. `ready` rises only after `osc_stable` has passed the SYNC_STAGES-deep synchroniser while `en` is high. `ready` high always implies `osc_on` high.
- R2: `clk_out` shows no rising edge while `ready` is low. Once `ready` is high it copies `osc_clk`, starting at the first falling edge of `osc_clk`.
- R3: `cal_val` equals CAL_RESET (default 180) from reset onwards and never changes.
- R4: `trim_eff` equals `cal_val` plus `trim_val`, where `trim_val` is read as two's complement. The sum is clamped to the range 0 to 255.
- R5: When `trim_wr` is high on an edge and lock mode is inactive, `trim_wdata` is loaded into `trim_val`. `trim_val` resets to 0.
- R6: `lock_active` becomes 1 only on an edge where `lock_req`, `ref_ready` and `ready` are all high. While `ref_ready` is low, a lock request has no effect on `lock_active` or on the trim.
- R7: On the first edge where `en` is sampled low, `ready` and `osc_on` drop to 0 and the output gate closes.
- R8: In lock mode, each window is REF_WINDOW reference periods (default 8) long and starts at a reference rising edge. If the count of oscillator rising edges in a window is below EXP_BASE shifted left by `range_sel`, `trim_val` steps up by 1. If the count is above that target, it steps down by 1. `trim_val` changes by at most 1 per edge, and repeated windows bring `trim_eff` close to the point where the count matches the target.
- R9: A `trim_wr` pulse while `lock_active` is high is ignored.
- R10: Lock mode converges in any range. Each step of `range_sel` doubles the target count.
- R11: After `en` is cleared and set again, `trim_val` and `trim_eff` keep their values and `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Oscillator on request (level) |
| osc_stable | input | 1 | Stable indication from the analog core (asynchronous) |
| osc_clk | input | 1 | Raw oscillator clock |
| ref_clk | input | 1 | 32.768 kHz reference clock |
| ref_ready | input | 1 | Reference clock is running and valid |
| lock_req | input | 1 | Lock mode request |
| range_sel | input | RANGE_W | Frequency range select; sets the lock target |
| trim_wr | input | 1 | Write strobe for the user trim |
| trim_wdata | input | TRIM_W | Signed user trim to write |
| osc_on | output | 1 | Power-on control to the analog core |
| ready | output | 1 | Oscillator ready flag |
| clk_out | output | 1 | Gated oscillator clock |
| lock_active | output | 1 | Lock mode running |
| cal_val | output | TRIM_W | Factory calibration value |
| trim_val | output | TRIM_W | Current signed user trim |
| trim_eff | output | TRIM_W | Clamped trim sent to the core |

## Verification
The bench counts `clk_out` edges during the startup interval before `ready` rises. A gate that opened on the enable alone, or on the unsynchronised stable level, would leak edges there. It writes trims that reach and pass the upper clamp, and negative trims, so a sum that wrapped or ignored the sign would give values such as 51 instead of 255. It runs lock mode from trims well away from the target in two ranges. A step with the wrong sign would drive the trim to a rail, and a target that ignored the range would settle at a different trim. It also checks that writes during lock, lock requests without a ready reference, and an off/on cycle leave the trim unchanged.

// File: rtl/rcosc_pkg.sv
`timescale 1ns/1ps
package rcosc_pkg;
   // One decision per measurement window
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;
endpackage

// File: rtl/rcosc_sync.sv
`timescale 1ns/1ps
module rcosc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcosc_ready_ctl.sv
`timescale 1ns/1ps
module rcosc_ready_ctl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic osc_stable,
   input  logic osc_clk,
   output logic osc_on,
   output logic ready,
   output logic clk_out
);
   logic stable_s;
   logic on_q;
   logic rdy_q;
   logic gate_q;

   rcosc_sync #(.STAGES(SYNC_STAGES)) u_stable_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (osc_stable),
      .q     (stable_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         rdy_q <= 1'b0;
      end else begin
         on_q  <= en;
         rdy_q <= en & stable_s;
      end
   end

   // Opens only on a low phase of the oscillator, so no runt high pulse
   always_ff @(negedge osc_clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= rdy_q;
   end

   assign osc_on  = on_q;
   assign ready   = rdy_q;
   assign clk_out = osc_clk & gate_q & rdy_q;
endmodule

// File: rtl/rcosc_trim_reg.sv
`timescale 1ns/1ps
module rcosc_trim_reg
   import rcosc_pkg::*;
#(
   parameter int                TRIM_W    = 8,
   parameter logic [TRIM_W-1:0] CAL_RESET = 8'd180
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TRIM_W-1:0] wr_data,
   input  logic              lock_on,
   input  step_e             step,
   output logic [TRIM_W-1:0] cal_val,
   output logic [TRIM_W-1:0] trim_val,
   output logic [TRIM_W-1:0] trim_eff
);
   localparam int                SUM_W    = TRIM_W + 2;
   localparam logic [TRIM_W-1:0] EFF_TOP  = '1;
   localparam logic [TRIM_W-1:0] EFF_BOT  = '0;
   localparam logic [TRIM_W-1:0] TRIM_TOP = {1'b0, {(TRIM_W-1){1'b1}}};
   localparam logic [TRIM_W-1:0] TRIM_BOT = {1'b1, {(TRIM_W-1){1'b0}}};
   localparam logic [TRIM_W-1:0] ONE      = TRIM_W'(1);

   logic [TRIM_W-1:0]       cal_q;
   logic [TRIM_W-1:0]       trim_q;
   logic signed [SUM_W-1:0] sum;
   logic [TRIM_W-1:0]       eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cal_q <= CAL_RESET;
      else        cal_q <= cal_q;
   end

   assign sum = $signed({2'b00, cal_q})
              + $signed({{2{trim_q[TRIM_W-1]}}, trim_q});

   always_comb begin
      if (sum < 0)                              eff = EFF_BOT;
      else if (sum > $signed({2'b00, EFF_TOP})) eff = EFF_TOP;
      else                                      eff = sum[TRIM_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q <= '0;
      end else if (lock_on) begin
         unique case (step)
            STEP_UP:   if (trim_q != TRIM_TOP && eff != EFF_TOP) trim_q <= trim_q + ONE;
            STEP_DOWN: if (trim_q != TRIM_BOT && eff != EFF_BOT) trim_q <= trim_q - ONE;
            default:   trim_q <= trim_q;
         endcase
      end else if (wr_en) begin
         trim_q <= wr_data;
      end
   end

   assign cal_val  = cal_q;
   assign trim_val = trim_q;
   assign trim_eff = eff;
endmodule

// File: rtl/rcosc_freq_lock.sv
`timescale 1ns/1ps
module rcosc_freq_lock
   import rcosc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REF_WINDOW  = 8,
   parameter int RANGE_W     = 2,
   parameter int EXP_BASE    = 32,
   parameter int DEAD_BAND   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lock_on,
   input  logic               osc_clk,
   input  logic               ref_clk,
   input  logic [RANGE_W-1:0] range_sel,
   output step_e              step
);
   localparam int MAX_EXP = EXP_BASE << ((1 << RANGE_W) - 1);
   localparam int CNT_W   = $clog2(MAX_EXP * 4 + 1);
   localparam int WIN_W   = $clog2(REF_WINDOW + 1);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(REF_WINDOW - 1);

   logic osc_s, ref_s, osc_d, ref_d;
   logic osc_rise, ref_rise;

   rcosc_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
      .clk(clk), .rst_n(rst_n), .d(osc_clk), .q(osc_s));
   rcosc_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .d(ref_clk), .q(ref_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_d <= 1'b0;
         ref_d <= 1'b0;
      end else begin
         osc_d <= osc_s;
         ref_d <= ref_s;
      end
   end

   assign osc_rise = osc_s & ~osc_d;
   assign ref_rise = ref_s & ~ref_d;

   logic             armed;
   logic [WIN_W-1:0] win_cnt;
   logic [CNT_W-1:0] osc_cnt;
   logic [CNT_W-1:0] osc_next;
   logic [CNT_W-1:0] target;
   logic             win_end;
   step_e            verdict;

   assign osc_next = (osc_rise && osc_cnt != '1) ? osc_cnt + CNT_W'(1) : osc_cnt;
   assign target   = CNT_W'(EXP_BASE) << range_sel;
   assign win_end  = armed && ref_rise && (win_cnt == WIN_LAST);

   if (DEAD_BAND == 0) begin : g_exact
      always_comb begin
         if (osc_next < target)      verdict = STEP_UP;
         else if (osc_next > target) verdict = STEP_DOWN;
         else                        verdict = STEP_HOLD;
      end
   end else begin : g_band
      int err;
      always_comb begin
         err = int'(osc_next) - int'(target);
         if (err < -DEAD_BAND)     verdict = STEP_UP;
         else if (err > DEAD_BAND) verdict = STEP_DOWN;
         else                      verdict = STEP_HOLD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         win_cnt <= '0;
         osc_cnt <= '0;
         step    <= STEP_HOLD;
      end else if (!lock_on) begin
         armed   <= 1'b0;
         win_cnt <= '0;
         osc_cnt <= '0;
         step    <= STEP_HOLD;
      end else begin
         step <= STEP_HOLD;
         if (!armed) begin
            if (ref_rise) begin
               armed   <= 1'b1;
               win_cnt <= '0;
               osc_cnt <= '0;
            end
         end else if (win_end) begin
            step    <= verdict;
            win_cnt <= '0;
            osc_cnt <= '0;
         end else begin
            if (ref_rise) win_cnt <= win_cnt + WIN_W'(1);
            osc_cnt <= osc_next;
         end
      end
   end
endmodule

// File: rtl/rcosc_ctrl.sv
`timescale 1ns/1ps
module rcosc_ctrl
   import rcosc_pkg::*;
#(
   parameter int                TRIM_W      = 8,
   parameter logic [TRIM_W-1:0] CAL_RESET   = 8'd180,
   parameter int                SYNC_STAGES = 2,
   parameter int                REF_WINDOW  = 8,
   parameter int                RANGE_W     = 2,
   parameter int                EXP_BASE    = 32,
   parameter int                DEAD_BAND   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               osc_stable,
   input  logic               osc_clk,
   input  logic               ref_clk,
   input  logic               ref_ready,
   input  logic               lock_req,
   input  logic [RANGE_W-1:0] range_sel,
   input  logic               trim_wr,
   input  logic [TRIM_W-1:0]  trim_wdata,
   output logic               osc_on,
   output logic               ready,
   output logic               clk_out,
   output logic               lock_active,
   output logic [TRIM_W-1:0]  cal_val,
   output logic [TRIM_W-1:0]  trim_val,
   output logic [TRIM_W-1:0]  trim_eff
);
   if (TRIM_W < 2) begin : g_chk_trim
      $error("TRIM_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REF_WINDOW < 1) begin : g_chk_win
      $error("REF_WINDOW must be at least 1");
   end
   if (RANGE_W < 1 || RANGE_W > 4) begin : g_chk_range
      $error("RANGE_W must be within 1..4");
   end
   if (EXP_BASE < 1 || DEAD_BAND < 0) begin : g_chk_exp
      $error("EXP_BASE must be positive and DEAD_BAND non-negative");
   end

   logic  rdy;
   logic  lock_q;
   step_e step;

   rcosc_ready_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ready (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .osc_stable (osc_stable),
      .osc_clk    (osc_clk),
      .osc_on     (osc_on),
      .ready      (rdy),
      .clk_out    (clk_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock_req & ref_ready & rdy;
   end

   rcosc_freq_lock #(
      .SYNC_STAGES (SYNC_STAGES),
      .REF_WINDOW  (REF_WINDOW),
      .RANGE_W     (RANGE_W),
      .EXP_BASE    (EXP_BASE),
      .DEAD_BAND   (DEAD_BAND)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_on   (lock_q),
      .osc_clk   (osc_clk),
      .ref_clk   (ref_clk),
      .range_sel (range_sel),
      .step      (step)
   );

   rcosc_trim_reg #(
      .TRIM_W    (TRIM_W),
      .CAL_RESET (CAL_RESET)
   ) u_trim (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (trim_wr),
      .wr_data  (trim_wdata),
      .lock_on  (lock_q),
      .step     (step),
      .cal_val  (cal_val),
      .trim_val (trim_val),
      .trim_eff (trim_eff)
   );

   assign ready       = rdy;
   assign lock_active = lock_q;
endmodule

// File: rtl/rcosc_ctrl_chk.sv
`timescale 1ns/1ps
module rcosc_ctrl_chk #(
   parameter int                TRIM_W    = 8,
   parameter logic [TRIM_W-1:0] CAL_RESET = 8'd180
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              ref_ready,
   input logic              lock_req,
   input logic              trim_wr,
   input logic [TRIM_W-1:0] trim_wdata,
   input logic              osc_on,
   input logic              ready,
   input logic              lock_active,
   input logic [TRIM_W-1:0] cal_val,
   input logic [TRIM_W-1:0] trim_val
);
   logic [TRIM_W-1:0]   prev_trim;
   logic signed [TRIM_W:0] trim_delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_trim <= '0;
      else        prev_trim <= trim_val;
   end

   assign trim_delta = $signed({trim_val[TRIM_W-1], trim_val})
                     - $signed({prev_trim[TRIM_W-1], prev_trim});

   p_ready_has_power_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> osc_on);

   p_cal_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cal_val == CAL_RESET);

   p_write_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_wr && !lock_active) |=> (trim_val == $past(trim_wdata)));

   p_no_ref_no_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_ready |=> !lock_active);

   p_lock_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_active) |-> $past(lock_req && ref_ready && ready));

   p_disable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!ready && !osc_on));

   p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |=> (trim_delta >= -1 && trim_delta <= 1));

   p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_active && trim_wr && trim_wdata != trim_val) |=>
         (trim_val != $past(trim_wdata) || trim_delta >= -1 && trim_delta <= 1));
endmodule

bind rcosc_ctrl rcosc_ctrl_chk #(
   .TRIM_W    (TRIM_W),
   .CAL_RESET (CAL_RESET)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .ref_ready   (ref_ready),
   .lock_req    (lock_req),
   .trim_wr     (trim_wr),
   .trim_wdata  (trim_wdata),
   .osc_on      (osc_on),
   .ready       (ready),
   .lock_active (lock_active),
   .cal_val     (cal_val),
   .trim_val    (trim_val)
);

// File: tb/rcosc_ctrl_tb_top.sv
`timescale 1ns/1ps
module rcosc_ctrl_tb_top;
   localparam int WIN_CYC   = 640;     // 8 reference periods of 1600 ns at 20 ns
   localparam int WDOG_CYC  = 150000;
   // {trim write, expected effective trim} with calibration 180
   localparam logic [15:0] TRIM_VEC [8] = '{
      16'h00B4, 16'h14C8, 16'h4BFF, 16'h4AFE,
      16'h7FFF, 16'h8034, 16'hECA0, 16'hB468 };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       osc_stable = 1'b0;
   logic       osc_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       ref_ready = 1'b0;
   logic       lock_req = 1'b0;
   logic [1:0] range_sel = 2'd0;
   logic       trim_wr = 1'b0;
   logic [7:0] trim_wdata = 8'd0;
   logic       osc_on, ready, clk_out, lock_active;
   logic [7:0] cal_val, trim_val, trim_eff;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int out_edges = 0;

   rcosc_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .osc_stable(osc_stable),
      .osc_clk(osc_clk), .ref_clk(ref_clk), .ref_ready(ref_ready),
      .lock_req(lock_req), .range_sel(range_sel), .trim_wr(trim_wr),
      .trim_wdata(trim_wdata), .osc_on(osc_on), .ready(ready),
      .clk_out(clk_out), .lock_active(lock_active), .cal_val(cal_val),
      .trim_val(trim_val), .trim_eff(trim_eff));

   always #10 clk = ~clk;
   initial forever #800 ref_clk = ~ref_clk;

   // Tunable oscillator model: frequency grows with trim and doubles per range
   initial begin
      real hp;
      forever begin
         if (!osc_on) begin
            osc_clk = 1'b0;
            @(posedge osc_on);
         end else begin
            hp = 200.0 * 256.0 / (real'(trim_eff) + 128.0) / real'(1 << range_sel);
            #(hp) osc_clk = ~osc_clk;
         end
      end
   end

   initial forever begin
      @(posedge osc_on);
      #3000;
      if (osc_on) osc_stable = 1'b1;
   end
   always @(negedge osc_on) osc_stable = 1'b0;

   always @(posedge clk_out) out_edges++;

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == WDOG_CYC) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         report();
      end
   end

   task automatic check_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_in(string req, int act, int lo, int hi);
      checks++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_trim(logic [7:0] v);
      @(negedge clk);
      trim_wr    = 1'b1;
      trim_wdata = v;
      @(negedge clk);
      trim_wr    = 1'b0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
   endtask

   initial begin
      int saved_tv, saved_te, delta;
      wait_cyc(5);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      check_eq("R1 reset ready", int'(ready), 0);
      check_eq("R1 reset osc_on", int'(osc_on), 0);
      check_eq("R6 reset lock_active", int'(lock_active), 0);
      check_eq("R3 reset cal_val", int'(cal_val), 180);
      check_eq("R5 reset trim_val", int'(trim_val), 0);
      check_eq("R4 reset trim_eff", int'(trim_eff), 180);

      // Startup: gate stays closed until ready
      en = 1'b1;
      out_edges = 0;
      @(negedge clk);
      check_eq("R1 osc_on after en", int'(osc_on), 1);
      wait_ready();
      check_eq("R1 ready after stable", int'(ready), 1);
      check_eq("R2 no clk_out edges before ready", out_edges, 0);
      wait_cyc(100);
      check_in("R2 clk_out runs after ready", out_edges, 1, 1000);

      // Trim vector table
      foreach (TRIM_VEC[k]) begin
         write_trim(TRIM_VEC[k][15:8]);
         check_eq("R5 trim_val load", int'(trim_val), int'(TRIM_VEC[k][15:8]));
         check_eq("R4 trim_eff clamp", int'(trim_eff), int'(TRIM_VEC[k][7:0]));
      end
      write_trim(8'h00);

      // Lock request without a ready reference
      lock_req = 1'b1;
      wait_cyc(3 * WIN_CYC);
      check_eq("R6 lock ignored lock_active", int'(lock_active), 0);
      check_eq("R6 lock ignored trim_val", int'(trim_val), 0);
      ref_ready = 1'b1;
      wait_cyc(2);
      check_eq("R6 lock entry", int'(lock_active), 1);

      // Lock in range 0 from effective trim 180
      wait_cyc(70 * WIN_CYC);
      check_in("R8 range0 converged trim_eff", int'(trim_eff), 118, 140);

      // Write during lock
      saved_tv = int'($signed(trim_val));
      write_trim(8'h7F);
      delta = int'($signed(trim_val)) - saved_tv;
      check_in("R9 write ignored in lock", delta, -1, 1);

      // Lock in range 1 from effective trim 160
      lock_req = 1'b0;
      wait_cyc(2);
      check_eq("R6 lock exit", int'(lock_active), 0);
      range_sel = 2'd1;
      write_trim(8'hEC);
      check_eq("R4 trim_eff before range1 lock", int'(trim_eff), 160);
      lock_req = 1'b1;
      wait_cyc(60 * WIN_CYC);
      check_in("R10 range1 converged trim_eff", int'(trim_eff), 118, 140);

      // Off / on cycle keeps trim
      lock_req = 1'b0;
      wait_cyc(2);
      saved_tv = int'(trim_val);
      saved_te = int'(trim_eff);
      en = 1'b0;
      @(negedge clk);
      check_eq("R7 ready drops", int'(ready), 0);
      check_eq("R7 osc_on drops", int'(osc_on), 0);
      out_edges = 0;
      wait_cyc(100);
      check_eq("R7 gate closed", out_edges, 0);
      check_eq("R11 trim_val kept while off", int'(trim_val), saved_tv);
      en = 1'b1;
      wait_ready();
      check_eq("R11 ready returns", int'(ready), 1);
      check_eq("R11 trim_eff kept", int'(trim_eff), saved_te);
      check_eq("R3 cal_val unchanged", int'(cal_val), 180);
      report();
   end
endmodule